// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between a requester's request path and its cache controller and gives that requester atomic load-linked/store-conditional and read-modify-write semantics. It holds one reservation made up of a valid bit, a line tag and a requester identifier. The reservation is armed when a locked read *completes*, not when it is issued. Every request presented on the check port is judged in the same cycle. A conditional (locked) write with no matching reservation is refused: it is not issued, and the tracking slot that the request path already allocated for it is handed back at once. A conditional write that passes clears the reservation at the clock edge on which it is accepted.

The completion port also drives a line block toward the controller. Completion of the read half of a read-modify-write raises the block for that line. Completion of the write half on the same line releases it. The coherence side is represented only by an external invalidate input, which kills the reservation when its line matches the tag. An invalidate also beats a reservation being armed for the same line in the same cycle. All locked and read-modify-write kinds are presented to the controller as one atomic request type.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held and no line is blocked: a locked write (kind 4) is refused and `blk_active` is 0.
- R2: When a locked-read completion (kind 3) is seen, the reservation is armed with that completion's line and identifier from the next cycle on. A locked write with the same line and identifier is then accepted: `chk_issue`=1, `chk_fail`=0.
- R3: A locked write whose line or identifier differs from the reservation is refused in the same cycle: `chk_fail`=1, `chk_release`=1, `chk_issue`=0.
- R4: A locked write that is accepted at a clock edge clears the reservation, so a second locked write to the same line and identifier is refused.
- R5: Every kind other than locked write (load 0, store 1, fetch 2, locked read 3, rmw read 5, rmw write 6) is issued whenever `chk_valid` is 1. None of them fails or releases a slot, and none of them changes the reservation.
- R6: `chk_ctype` maps fetch to 0, load to 1 and store to 2. It maps locked read, locked write, rmw read and rmw write to 3 (atomic).
- R7: A completion of kind 5 (rmw read) sets `blk_active` and loads `blk_line` with that line from the next cycle on.
- R8: A completion of kind 6 (rmw write) whose line equals `blk_line` releases the block on the next cycle. One with a different line leaves the block in place.
- R9: An invalidate whose line equals the reservation tag clears the reservation. An invalidate on another line leaves it intact.
- R10: When a locked-read completion and an invalidate for the same line land in the same cycle, the invalidate wins and no reservation is left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | A request is presented for checking this cycle |
| chk_kind | input | 3 | Request kind code (0 load, 1 store, 2 fetch, 3 locked read, 4 locked write, 5 rmw read, 6 rmw write) |
| chk_line | input | LINE_W | Line address of the request |
| chk_id | input | ID_W | Requester identifier of the request |
| chk_issue | output | 1 | Request may be sent to the controller |
| chk_fail | output | 1 | Conditional write refused |
| chk_release | output | 1 | Tracking slot of the refused request is to be freed |
| chk_ctype | output | 2 | Controller request type (0 fetch, 1 load, 2 store, 3 atomic) |
| cpl_valid | input | 1 | A completion event is presented |
| cpl_kind | input | 3 | Kind code of the completed request |
| cpl_line | input | LINE_W | Line address of the completion |
| cpl_id | input | ID_W | Requester identifier of the completion |
| inv_valid | input | 1 | External invalidate of a line |
| inv_line | input | LINE_W | Line being invalidated |
| blk_active | output | 1 | Controller must hold off other requests to `blk_line` |
| blk_line | output | LINE_W | Line currently blocked |

## Verification
The hardest situation to reach from the ports is a reservation being armed and invalidated for the same line in one cycle. The bench presents the locked-read completion and the invalidate with matching lines in the same negative-edge window, so both are taken at one rising edge. The reservation is never visible directly. The bench therefore probes it with a locked write held only between two edges: it reads the combinational verdict and drops `chk_valid` before the next rising edge, so the probe itself does not consume the reservation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [2:0] {
    K_LOAD    = 3'd0,
    K_STORE   = 3'd1,
    K_FETCH   = 3'd2,
    K_LOCK_RD = 3'd3,
    K_LOCK_WR = 3'd4,
    K_RMW_RD  = 3'd5,
    K_RMW_WR  = 3'd6
  } req_kind_e;

  typedef enum logic [1:0] {
    C_FETCH  = 2'd0,
    C_LOAD   = 2'd1,
    C_STORE  = 2'd2,
    C_ATOMIC = 2'd3
  } ctrl_type_e;

  function automatic ctrl_type_e ctrl_of(input logic [2:0] kind);
    case (kind)
      K_FETCH:  return C_FETCH;
      K_STORE:  return C_STORE;
      K_LOCK_RD, K_LOCK_WR, K_RMW_RD, K_RMW_WR: return C_ATOMIC;
      default:  return C_LOAD;
    endcase
  endfunction

  function automatic logic is_cond_write(input logic [2:0] kind);
    return kind == K_LOCK_WR;
  endfunction

endpackage

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [LINE_W-1:0] set_line,
  input  logic [ID_W-1:0]   set_id,
  input  logic              sc_clr,
  input  logic [LINE_W-1:0] sc_line,
  input  logic              inv_en,
  input  logic [LINE_W-1:0] inv_line,
  output logic              r_valid,
  output logic [LINE_W-1:0] r_line,
  output logic [ID_W-1:0]   r_id
);
  logic              n_valid;
  logic [LINE_W-1:0] n_line;
  logic [ID_W-1:0]   n_id;

  // Order: conditional-write clear, then arm, then invalidate (last word).
  always_comb begin
    n_valid = r_valid;
    n_line  = r_line;
    n_id    = r_id;
    if (sc_clr && r_valid && (r_line == sc_line)) n_valid = 1'b0;
    if (set_en) begin
      n_valid = 1'b1;
      n_line  = set_line;
      n_id    = set_id;
    end
    if (inv_en && (inv_line == n_line)) n_valid = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_line  <= '0;
      r_id    <= '0;
    end else begin
      r_valid <= n_valid;
      r_line  <= n_line;
      r_id    <= n_id;
    end
  end
endmodule

// File: rtl/llsc_gate.sv
module llsc_gate
  import llsc_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input  logic              chk_valid,
  input  logic [2:0]        chk_kind,
  input  logic [LINE_W-1:0] chk_line,
  input  logic [ID_W-1:0]   chk_id,
  input  logic              r_valid,
  input  logic [LINE_W-1:0] r_line,
  input  logic [ID_W-1:0]   r_id,
  output logic              issue,
  output logic              fail,
  output logic              sc_ok,
  output logic [1:0]        ctype
);
  logic hit;
  logic cond;

  assign hit   = r_valid && (r_line == chk_line) && (r_id == chk_id);
  assign cond  = is_cond_write(chk_kind);
  assign fail  = chk_valid && cond && !hit;
  assign sc_ok = chk_valid && cond && hit;
  assign issue = chk_valid && !fail;
  assign ctype = ctrl_of(chk_kind);
endmodule

// File: rtl/llsc_blk.sv
module llsc_blk
  import llsc_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_kind,
  input  logic [LINE_W-1:0] cpl_line,
  output logic              blk_active,
  output logic [LINE_W-1:0] blk_line
);
  logic raise;
  logic drop;

  assign raise = cpl_valid && (cpl_kind == K_RMW_RD);
  assign drop  = cpl_valid && (cpl_kind == K_RMW_WR) && blk_active && (cpl_line == blk_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_active <= 1'b0;
      blk_line   <= '0;
    end else if (raise) begin
      blk_active <= 1'b1;
      blk_line   <= cpl_line;
    end else if (drop) begin
      blk_active <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [2:0]        chk_kind,
  input  logic [LINE_W-1:0] chk_line,
  input  logic [ID_W-1:0]   chk_id,
  output logic              chk_issue,
  output logic              chk_fail,
  output logic              chk_release,
  output logic [1:0]        chk_ctype,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_kind,
  input  logic [LINE_W-1:0] cpl_line,
  input  logic [ID_W-1:0]   cpl_id,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              blk_active,
  output logic [LINE_W-1:0] blk_line
);
  // Named internal events, brought out for the checker.
  logic              set_evt;
  logic              sc_ok;
  logic              resv_valid;
  logic [LINE_W-1:0] resv_line;
  logic [ID_W-1:0]   resv_id;

  assign set_evt     = cpl_valid && (cpl_kind == K_LOCK_RD);
  assign chk_release = chk_fail;

  llsc_resv #(.LINE_W(LINE_W), .ID_W(ID_W)) u_resv (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (set_evt),
    .set_line (cpl_line),
    .set_id   (cpl_id),
    .sc_clr   (sc_ok),
    .sc_line  (chk_line),
    .inv_en   (inv_valid),
    .inv_line (inv_line),
    .r_valid  (resv_valid),
    .r_line   (resv_line),
    .r_id     (resv_id)
  );

  llsc_gate #(.LINE_W(LINE_W), .ID_W(ID_W)) u_gate (
    .chk_valid (chk_valid),
    .chk_kind  (chk_kind),
    .chk_line  (chk_line),
    .chk_id    (chk_id),
    .r_valid   (resv_valid),
    .r_line    (resv_line),
    .r_id      (resv_id),
    .issue     (chk_issue),
    .fail      (chk_fail),
    .sc_ok     (sc_ok),
    .ctype     (chk_ctype)
  );

  llsc_blk #(.LINE_W(LINE_W)) u_blk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpl_valid  (cpl_valid),
    .cpl_kind   (cpl_kind),
    .cpl_line   (cpl_line),
    .blk_active (blk_active),
    .blk_line   (blk_line)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_valid,
  input logic [2:0]        chk_kind,
  input logic [LINE_W-1:0] chk_line,
  input logic              chk_issue,
  input logic              chk_fail,
  input logic              chk_release,
  input logic [1:0]        chk_ctype,
  input logic              cpl_valid,
  input logic [2:0]        cpl_kind,
  input logic [LINE_W-1:0] cpl_line,
  input logic              inv_valid,
  input logic [LINE_W-1:0] inv_line,
  input logic              blk_active,
  input logic [LINE_W-1:0] blk_line,
  input logic              set_evt,
  input logic              sc_ok,
  input logic              resv_valid,
  input logic [LINE_W-1:0] resv_line
);
  p_fail_no_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail |-> (!chk_issue && chk_release));

  p_sc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_ok && !set_evt) |=> !(resv_valid && resv_line == $past(chk_line)));

  p_plain_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_kind != 3'd4) |-> (chk_issue && !chk_fail));

  p_atomic_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_kind >= 3'd3 && chk_kind <= 3'd6) |-> chk_ctype == 2'd3);

  p_blk_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_kind == 3'd5) |=> (blk_active && blk_line == $past(cpl_line)));

  p_blk_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_active && !(cpl_valid && (cpl_kind == 3'd5 || (cpl_kind == 3'd6 && cpl_line == blk_line))))
      |=> (blk_active && $stable(blk_line)));

  p_inv_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && set_evt && inv_line == cpl_line) |=> !resv_valid);
endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chk_valid   (chk_valid),
  .chk_kind    (chk_kind),
  .chk_line    (chk_line),
  .chk_issue   (chk_issue),
  .chk_fail    (chk_fail),
  .chk_release (chk_release),
  .chk_ctype   (chk_ctype),
  .cpl_valid   (cpl_valid),
  .cpl_kind    (cpl_kind),
  .cpl_line    (cpl_line),
  .inv_valid   (inv_valid),
  .inv_line    (inv_line),
  .blk_active  (blk_active),
  .blk_line    (blk_line),
  .set_evt     (set_evt),
  .sc_ok       (sc_ok),
  .resv_valid  (resv_valid),
  .resv_line   (resv_line)
);

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;
  localparam int LW = 26;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chk_valid = 1'b0;
  logic [2:0]    chk_kind = '0;
  logic [LW-1:0] chk_line = '0;
  logic [IW-1:0] chk_id = '0;
  logic          chk_issue, chk_fail, chk_release;
  logic [1:0]    chk_ctype;
  logic          cpl_valid = 1'b0;
  logic [2:0]    cpl_kind = '0;
  logic [LW-1:0] cpl_line = '0;
  logic [IW-1:0] cpl_id = '0;
  logic          inv_valid = 1'b0;
  logic [LW-1:0] inv_line = '0;
  logic          blk_active;
  logic [LW-1:0] blk_line;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  llsc_monitor #(.LINE_W(LW), .ID_W(IW)) u_llsc_monitor (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [1:0] exp_ctype(input logic [2:0] k);
    if (k == 3'd2) return 2'd0;
    if (k == 3'd1) return 2'd2;
    if (k == 3'd0) return 2'd1;
    return 2'd3;
  endfunction

  // Present a check between edges, sample, withdraw before the next edge.
  task automatic probe(input logic [2:0] k, input logic [LW-1:0] ln, input logic [IW-1:0] id,
                       output logic iss, output logic fl, output logic rel, output logic [1:0] ct);
    @(negedge clk);
    chk_valid = 1'b1; chk_kind = k; chk_line = ln; chk_id = id;
    #2;
    iss = chk_issue; fl = chk_fail; rel = chk_release; ct = chk_ctype;
    chk_valid = 1'b0;
  endtask

  // Present a check that is taken at the next rising edge.
  task automatic commit(input logic [2:0] k, input logic [LW-1:0] ln, input logic [IW-1:0] id,
                        output logic iss, output logic fl);
    @(negedge clk);
    chk_valid = 1'b1; chk_kind = k; chk_line = ln; chk_id = id;
    #2;
    iss = chk_issue; fl = chk_fail;
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  task automatic complete(input logic [2:0] k, input logic [LW-1:0] ln, input logic [IW-1:0] id);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_kind = k; cpl_line = ln; cpl_id = id;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic invalidate(input logic [LW-1:0] ln);
    @(negedge clk);
    inv_valid = 1'b1; inv_line = ln;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic i, f, r; logic [1:0] c;
    check("R1 blk_active after reset", blk_active, 0);
    probe(3'd4, 26'h10, 4'd1, i, f, r, c);
    check("R1 locked write refused after reset", f, 1);
  endtask

  task automatic t_ll_sc_pass;
    logic i, f, r; logic [1:0] c;
    complete(3'd3, 26'h100, 4'd2);
    probe(3'd4, 26'h100, 4'd2, i, f, r, c);
    check("R2 matching SC issue", i, 1);
    check("R2 matching SC not failed", f, 0);
  endtask

  task automatic t_sc_mismatch;
    logic i, f, r; logic [1:0] c;
    probe(3'd4, 26'h101, 4'd2, i, f, r, c);
    check("R3 wrong line fail", f, 1);
    check("R3 wrong line release", r, 1);
    check("R3 wrong line not issued", i, 0);
    probe(3'd4, 26'h100, 4'd3, i, f, r, c);
    check("R3 wrong id fail", f, 1);
  endtask

  task automatic t_plain_kinds;
    logic i, f, r; logic [1:0] c;
    for (int k = 0; k < 7; k++) begin
      if (k == 4) continue;
      commit(3'(k), 26'h100, 4'd9, i, f);
      check("R5 plain kind issued", i, 1);
      check("R5 plain kind not failed", f, 0);
    end
    probe(3'd4, 26'h100, 4'd2, i, f, r, c);
    check("R5 reservation survives plain kinds", i, 1);
    for (int k = 0; k < 7; k++) begin
      probe(3'(k), 26'h5, 4'd0, i, f, r, c);
      check("R6 controller type", c, exp_ctype(3'(k)));
    end
  endtask

  task automatic t_sc_twice;
    logic i, f, r; logic [1:0] c;
    commit(3'd4, 26'h100, 4'd2, i, f);
    check("R4 first SC accepted", i, 1);
    probe(3'd4, 26'h100, 4'd2, i, f, r, c);
    check("R4 second SC refused", f, 1);
  endtask

  task automatic t_rmw_block;
    complete(3'd5, 26'h222, 4'd0);
    check("R7 block raised", blk_active, 1);
    check("R7 block line", blk_line, 26'h222);
    complete(3'd6, 26'h223, 4'd0);
    check("R8 other line keeps block", blk_active, 1);
    complete(3'd6, 26'h222, 4'd0);
    check("R8 matching line releases", blk_active, 0);
  endtask

  task automatic t_invalidate;
    logic i, f, r; logic [1:0] c;
    complete(3'd3, 26'h300, 4'd5);
    invalidate(26'h301);
    probe(3'd4, 26'h300, 4'd5, i, f, r, c);
    check("R9 other-line invalidate keeps reservation", i, 1);
    invalidate(26'h300);
    probe(3'd4, 26'h300, 4'd5, i, f, r, c);
    check("R9 matching invalidate clears", f, 1);
  endtask

  task automatic t_same_cycle;
    logic i, f, r; logic [1:0] c;
    @(negedge clk);
    cpl_valid = 1'b1; cpl_kind = 3'd3; cpl_line = 26'h400; cpl_id = 4'd7;
    inv_valid = 1'b1; inv_line = 26'h400;
    @(negedge clk);
    cpl_valid = 1'b0; inv_valid = 1'b0;
    probe(3'd4, 26'h400, 4'd7, i, f, r, c);
    check("R10 invalidate wins same cycle", f, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ll_sc_pass();
    t_sc_mismatch();
    t_plain_kinds();
    t_sc_twice();
    t_rmw_block();
    t_invalidate();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule